// File: doc/BRIEF.md
# Triple Timer Register Bank

This block holds three independent 16-bit timer channels behind one word-addressed bus with single-cycle read and write strobes. Each channel has a clock-control register (prescaler), a counter-control register, an interval limit, three match values, a sticky interrupt-flag register, an interrupt-enable mask and an event-control field. Each channel drives its own interrupt line.

The address map is interleaved by register type. Word index `w` selects register type `w / 3` and channel `w % 3`. Every type therefore takes three adjacent words, one for each channel. Reading a channel's flag register returns the flags and clears them. Read data is registered.

Top module: `tri_timer_regs`

## Requirements
- R1: Word index w in 0..32 selects channel w%3 and a type given by w/3 in this order: 0 clock control, 1 counter control, 2 count value, 3 interval, 4/5/6 match A/B/C, 7 interrupt flags, 8 interrupt enable, 9 event control, 10 event count. A flag read clears only the one addressed channel.
- R2: Writes keep only these bits: 6 bits [5:0] for clock control and interrupt enable, 16 bits for interval and match values, 3 bits [2:0] for event control. Reads return the stored value, zero-extended to 32 bits.
- R3: Counter-control bits are: [0] stop, [1] interval mode, [2] count down, [3] match enable, [4] write-only zero request that clears the count and always reads 0, [5] plain storage. After reset this register reads 0x21 and every other register reads 0.
- R4: A count-value read returns the channel's current 16-bit count. Writes to it have no effect.
- R5: The count advances one step per tick while stop is 0. With clock-control bit 0 clear there is a tick every cycle. With it set, there is a tick every 2^(S+1) cycles, where S is clock-control bits [4:1]. Counting up wraps from the limit to 0; counting down wraps from 0 to the limit. The limit is the interval value in interval mode and 0xFFFF otherwise. A stopped count holds.
- R6: Flag bit 0 is set on a wrap in interval mode. Flag bit 4 is set on a wrap otherwise. Flag bits 1, 2 and 3 are set when, with match enable on, a tick moves the count onto match A, B or C.
- R7: A flag-register read returns the flags of that channel and clears them. Writes to the flag register have no effect. A flag is cleared only by such a read.
- R8: irq[c] is high exactly when channel c has a flag bit set whose enable bit is also set.
- R9: Reads of word indices 33 and above return 0, and writes to them change nothing. Event-count reads return 0, and writes to event count have no effect.
- R10: rdata takes the read value on the clock edge that samples rd_en and keeps it until the next read. Presenting a flag address without rd_en clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | ADDR_W (10) | Word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 3 | One interrupt line per channel |

## Verification
The assertions check several properties on every cycle:
- At most one channel receives a flag clear at a time.
- A flag bit never drops unless its channel was cleared.
- A stopped count without a control write holds its value.
- Unmapped reads return zero.
- rdata holds between reads.

Some behaviour can only be shown by the bench's scenarios. This covers the exact count after a known number of ticks in each direction and prescale setting, which flags each wrap and match sets, the interrupt level, and the per-type write masks under random traffic.

// File: rtl/tri_tmr_pkg.sv
package tri_tmr_pkg;

    localparam int NUM_CH    = 3;
    localparam int CH_W      = 2;
    localparam int DATA_W    = 32;
    localparam int CFG_W     = 6;
    localparam int EVC_W     = 3;
    localparam int PS_SEL_W  = 4;
    localparam int NUM_MATCH = 3;
    localparam int NUM_KINDS = 11;

    // counter-control bit positions
    localparam int CB_STOP  = 0;
    localparam int CB_INTV  = 1;
    localparam int CB_DOWN  = 2;
    localparam int CB_MATCH = 3;
    localparam int CB_ZERO  = 4;
    localparam logic [CFG_W-1:0] CTRL_RST_VAL = 6'h21;

    // flag bit positions
    localparam int FB_INTV = 0;
    localparam int FB_M0   = 1;
    localparam int FB_OVF  = 4;

    // order follows the address map
    typedef enum logic [3:0] {
        RK_CLK    = 4'd0,
        RK_CTRL   = 4'd1,
        RK_COUNT  = 4'd2,
        RK_INTV   = 4'd3,
        RK_MATCH0 = 4'd4,
        RK_MATCH1 = 4'd5,
        RK_MATCH2 = 4'd6,
        RK_STAT   = 4'd7,
        RK_IEN    = 4'd8,
        RK_EVCTL  = 4'd9,
        RK_EVCNT  = 4'd10,
        RK_NONE   = 4'd15
    } reg_kind_e;

    typedef struct packed {
        logic            hit;
        reg_kind_e       kind;
        logic [CH_W-1:0] ch;
    } reg_sel_t;

    function automatic logic [DATA_W-1:0] kind_mask(input reg_kind_e k);
        case (k)
            RK_CLK, RK_IEN:                        return DATA_W'(6'h3F);
            RK_CTRL:                               return DATA_W'(6'h3F);
            RK_INTV, RK_MATCH0, RK_MATCH1, RK_MATCH2: return DATA_W'(16'hFFFF);
            RK_EVCTL:                              return DATA_W'(3'h7);
            default:                               return '0;
        endcase
    endfunction

endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
    import tri_tmr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    logic [ADDR_W-1:0] quo;
    logic [ADDR_W-1:0] rem;

    always_comb begin
        quo      = addr / ADDR_W'(NUM_CH);
        rem      = addr % ADDR_W'(NUM_CH);
        sel.hit  = quo < ADDR_W'(NUM_KINDS);
        sel.kind = sel.hit ? reg_kind_e'(quo[3:0]) : RK_NONE;
        sel.ch   = sel.hit ? rem[CH_W-1:0] : '0;
    end

    wire _unused_rem = &{1'b0, rem};

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             ps_en,
    input  logic [SEL_W-1:0] ps_sel,
    output logic             tick
);
    localparam int DIV_W = (1 << SEL_W) + 1;

    logic [DIV_W-1:0] pre_q;
    logic [DIV_W-1:0] last;
    logic             at_end;

    assign last   = (DIV_W'(1) << ({1'b0, ps_sel} + 1'b1)) - DIV_W'(1);
    assign at_end = pre_q >= last;
    assign tick   = run && (!ps_en || at_end);

    always_ff @(posedge clk) begin
        if (rst || !run || !ps_en) pre_q <= '0;
        else if (at_end)           pre_q <= '0;
        else                       pre_q <= pre_q + 1'b1;
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tri_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wr_clk,
    input  logic                                wr_ctrl,
    input  logic                                wr_intv,
    input  logic [NUM_MATCH-1:0]                wr_match,
    input  logic                                wr_ien,
    input  logic                                wr_evctl,
    input  logic [CNT_W-1:0]                    wd,
    input  logic                                stat_clr,
    output logic [CFG_W-1:0]                    clk_cfg,
    output logic [CFG_W-1:0]                    ctrl_cfg,
    output logic [CNT_W-1:0]                    intv,
    output logic [NUM_MATCH-1:0][CNT_W-1:0]     match,
    output logic [CFG_W-1:0]                    ien,
    output logic [EVC_W-1:0]                    evctl,
    output logic [CNT_W-1:0]                    count,
    output logic [CFG_W-1:0]                    flags,
    output logic                                irq
);
    logic [CFG_W-1:0]                clk_q, ctrl_q, ien_q, flags_q, set_vec;
    logic [CNT_W-1:0]                intv_q, cnt_q, limit, cnt_nx;
    logic [NUM_MATCH-1:0][CNT_W-1:0] match_q;
    logic [EVC_W-1:0]                evctl_q;
    logic                            tick, wrap, zero_req;

    tmr_prescale #(.SEL_W(PS_SEL_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .run    (!ctrl_q[CB_STOP]),
        .ps_en  (clk_q[0]),
        .ps_sel (clk_q[PS_SEL_W:1]),
        .tick   (tick)
    );

    assign limit    = ctrl_q[CB_INTV] ? intv_q : '1;
    assign wrap     = ctrl_q[CB_DOWN] ? (cnt_q == '0) : (cnt_q == limit);
    assign cnt_nx   = ctrl_q[CB_DOWN] ? (wrap ? limit : cnt_q - 1'b1)
                                      : (wrap ? '0    : cnt_q + 1'b1);
    assign zero_req = wr_ctrl && wd[CB_ZERO];

    always_comb begin
        set_vec = '0;
        if (tick) begin
            if (wrap) set_vec[ctrl_q[CB_INTV] ? FB_INTV : FB_OVF] = 1'b1;
            for (int i = 0; i < NUM_MATCH; i++)
                if (ctrl_q[CB_MATCH] && cnt_nx == match_q[i])
                    set_vec[FB_M0 + i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q   <= '0;
            ctrl_q  <= CTRL_RST_VAL;
            intv_q  <= '0;
            match_q <= '0;
            ien_q   <= '0;
            evctl_q <= '0;
            cnt_q   <= '0;
            flags_q <= '0;
        end else begin
            if (wr_clk)   clk_q   <= wd[CFG_W-1:0];
            if (wr_ctrl)  ctrl_q  <= wd[CFG_W-1:0] & ~(CFG_W'(1) << CB_ZERO);
            if (wr_intv)  intv_q  <= wd;
            for (int i = 0; i < NUM_MATCH; i++)
                if (wr_match[i]) match_q[i] <= wd;
            if (wr_ien)   ien_q   <= wd[CFG_W-1:0];
            if (wr_evctl) evctl_q <= wd[EVC_W-1:0];
            if (zero_req)  cnt_q <= '0;
            else if (tick) cnt_q <= cnt_nx;
            flags_q <= (stat_clr ? '0 : flags_q) | set_vec;
        end
    end

    assign clk_cfg  = clk_q;
    assign ctrl_cfg = ctrl_q;
    assign intv     = intv_q;
    assign match    = match_q;
    assign ien      = ien_q;
    assign evctl    = evctl_q;
    assign count    = cnt_q;
    assign flags    = flags_q;
    assign irq      = |(flags_q & ien_q);

    // R5: a stopped counter with no control write keeps its value
    p_hold_when_stopped_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[CB_STOP] && !wr_ctrl) |=> $stable(cnt_q));

    // R7: flag bits only drop after a clear strobe
    p_flags_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        !stat_clr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

endmodule

// File: rtl/tri_timer_regs.sv
module tri_timer_regs
    import tri_tmr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] irq
);
    reg_sel_t          sel;
    logic [DATA_W-1:0] wd_m, rd_val, rdata_q;
    logic [NUM_CH-1:0] clr_vec;

    logic [CFG_W-1:0]                clk_cfg  [NUM_CH];
    logic [CFG_W-1:0]                ctrl_cfg [NUM_CH];
    logic [CNT_W-1:0]                intv     [NUM_CH];
    logic [NUM_MATCH-1:0][CNT_W-1:0] mt       [NUM_CH];
    logic [CFG_W-1:0]                ien      [NUM_CH];
    logic [EVC_W-1:0]                evctl    [NUM_CH];
    logic [CNT_W-1:0]                count    [NUM_CH];
    logic [CFG_W-1:0]                flags    [NUM_CH];

    tmr_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    assign wd_m = wdata & kind_mask(sel.kind);
    wire _unused_wd = &{1'b0, wd_m};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic                 me;
        logic [NUM_MATCH-1:0] wr_m;
        assign me = sel.hit && (sel.ch == CH_W'(c));
        for (genvar m = 0; m < NUM_MATCH; m++) begin : g_m
            assign wr_m[m] = wr_en && me && (sel.kind == reg_kind_e'(int'(RK_MATCH0) + m));
        end
        assign clr_vec[c] = rd_en && me && (sel.kind == RK_STAT);

        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .wr_clk   (wr_en && me && sel.kind == RK_CLK),
            .wr_ctrl  (wr_en && me && sel.kind == RK_CTRL),
            .wr_intv  (wr_en && me && sel.kind == RK_INTV),
            .wr_match (wr_m),
            .wr_ien   (wr_en && me && sel.kind == RK_IEN),
            .wr_evctl (wr_en && me && sel.kind == RK_EVCTL),
            .wd       (wd_m[CNT_W-1:0]),
            .stat_clr (clr_vec[c]),
            .clk_cfg  (clk_cfg[c]),
            .ctrl_cfg (ctrl_cfg[c]),
            .intv     (intv[c]),
            .match    (mt[c]),
            .ien      (ien[c]),
            .evctl    (evctl[c]),
            .count    (count[c]),
            .flags    (flags[c]),
            .irq      (irq[c])
        );
    end

    always_comb begin
        rd_val = '0;
        if (sel.hit) begin
            case (sel.kind)
                RK_CLK:    rd_val = DATA_W'(clk_cfg[sel.ch]);
                RK_CTRL:   rd_val = DATA_W'(ctrl_cfg[sel.ch]);
                RK_COUNT:  rd_val = DATA_W'(count[sel.ch]);
                RK_INTV:   rd_val = DATA_W'(intv[sel.ch]);
                RK_MATCH0: rd_val = DATA_W'(mt[sel.ch][0]);
                RK_MATCH1: rd_val = DATA_W'(mt[sel.ch][1]);
                RK_MATCH2: rd_val = DATA_W'(mt[sel.ch][2]);
                RK_STAT:   rd_val = DATA_W'(flags[sel.ch]);
                RK_IEN:    rd_val = DATA_W'(ien[sel.ch]);
                RK_EVCTL:  rd_val = DATA_W'(evctl[sel.ch]);
                default:   rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_val;
    end

    assign rdata = rdata_q;

    // R1: a flag read clears at most one channel
    p_single_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_vec));

    // R9: unmapped reads return zero
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !sel.hit) |=> (rdata == '0));

    // R10: read data only changes on a read strobe
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

endmodule

// File: tb/test_tri_timer_regs.sv
module test_tri_timer_regs;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 10;

    // register type indices (R1)
    localparam int K_CLK = 0, K_CTRL = 1, K_CNT = 2, K_INTV = 3, K_MA = 4,
                   K_MB = 5, K_MC = 6, K_STAT = 7, K_IEN = 8, K_EVC = 9, K_EVN = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [2:0]        irq;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] mdl [11][3];

    tri_timer_regs #(.ADDR_W(ADDR_W), .CNT_W(16)) i_tri_timer_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [31:0] wmask(input int k);
        case (k)
            K_CLK, K_IEN:        return 32'h3F;
            K_CTRL:              return 32'h2F;   // R3: zero request not stored
            K_INTV, K_MA, K_MB, K_MC: return 32'hFFFF;
            K_EVC:               return 32'h7;
            default:             return 32'h0;
        endcase
    endfunction

    function automatic bit writable(input int k);
        return wmask(k) != 0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input int w, input logic [31:0] d);
        addr = ADDR_W'(w); wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input int w, output logic [31:0] d);
        addr = ADDR_W'(w); rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic reg_wr(input int k, input int ch, input logic [31:0] d);
        bus_wr(k*3 + ch, d);
        if (writable(k)) mdl[k][ch] = d & wmask(k);
        if (k == K_CTRL && d[4]) mdl[K_CNT][ch] = 0;
    endtask

    task automatic reg_chk(input string req, input int k, input int ch);
        logic [31:0] v;
        bus_rd(k*3 + ch, v);
        check(req, v, mdl[k][ch]);
    endtask

    task automatic sweep(input string req);
        for (int k = 0; k < 11; k++)
            if (k != K_STAT)
                for (int c = 0; c < 3; c++) reg_chk(req, k, c);
    endtask

    // runs channel ch for ticks+... : returns after stop write; n edges counted
    task automatic run_for(input int ch, input logic [31:0] run_ctrl, input int k);
        reg_wr(K_CTRL, ch, 32'h11);
        reg_wr(K_CTRL, ch, run_ctrl);
        idle(k);
        reg_wr(K_CTRL, ch, 32'h01);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, hold;
        void'($urandom(32'h1A2B3C4D));
        for (int k = 0; k < 11; k++)
            for (int c = 0; c < 3; c++) mdl[k][c] = 0;
        for (int c = 0; c < 3; c++) mdl[K_CTRL][c] = 32'h21;

        idle(3);
        rst = 1'b0;
        idle(1);

        // R3: reset values
        check("R3 irq after reset", 32'(irq), 32'h0);
        sweep("R3 reset value");

        // R1 R2 R4 R9: random traffic
        for (int i = 0; i < 80; i++) begin
            int k, ch;
            logic [31:0] d;
            k = $urandom_range(0, 11);
            d = $urandom;
            if (k == 11) begin
                bus_wr($urandom_range(33, 1023), d);           // R9 ignored write
                bus_rd($urandom_range(33, 1023), v);
                check("R9 unmapped read", v, 32'h0);
                ch = $urandom_range(0, 2);
                reg_chk("R9 unmapped write no effect", K_INTV, ch);
            end else begin
                ch = $urandom_range(0, 2);
                if (k == K_CTRL) d = d | 32'h1;                // keep stopped
                reg_wr(k, ch, d);
                if (k == K_STAT) reg_chk("R7 flag write ignored", K_CNT, ch);
                else if (k == K_CNT) reg_chk("R4 count write ignored", K_CNT, ch);
                else if (k == K_EVN) reg_chk("R9 event count reads 0", K_EVN, ch);
                else reg_chk("R2 masked readback", k, ch);
            end
        end
        sweep("R1 map after random traffic");

        // R5: count up, every cycle, non-interval, 7 ticks
        reg_wr(K_CLK, 1, 0); reg_wr(K_IEN, 1, 0);
        run_for(1, 32'h00, 6);
        mdl[K_CNT][1] = 7;
        reg_chk("R5 up count", K_CNT, 1);
        reg_chk("R5 other channel idle", K_CNT, 0);
        reg_chk("R5 other channel idle", K_CNT, 2);
        bus_rd(K_STAT*3 + 1, v);
        check("R6 no flags before wrap", v, 32'h0);

        // R5 R6 R8: interval mode, limit 4, 7 ticks -> 1,2,3,4,0,1,2
        reg_wr(K_INTV, 1, 4); reg_wr(K_IEN, 1, 32'h01);
        run_for(1, 32'h02, 6);
        mdl[K_CNT][1] = 2;
        reg_chk("R5 interval wrap count", K_CNT, 1);
        check("R8 irq raised", 32'(irq[1]), 32'h1);
        addr = ADDR_W'(K_STAT*3 + 1);                          // R10 decode without strobe
        idle(2);
        check("R10 no clear without rd_en", 32'(irq[1]), 32'h1);
        reg_wr(K_STAT, 1, 32'h0);
        check("R7 flag write has no effect", 32'(irq[1]), 32'h1);
        bus_rd(K_STAT*3 + 1, v);
        check("R6 interval flag", v, 32'h01);
        check("R7 read clears irq", 32'(irq[1]), 32'h0);
        hold = rdata;
        idle(3);
        check("R10 rdata holds", rdata, hold);
        bus_rd(K_STAT*3 + 1, v);
        check("R7 flags cleared", v, 32'h0);

        // R5 R6 R8: count down, non-interval, 3 ticks -> FFFF FFFE FFFD
        reg_wr(K_CLK, 2, 0); reg_wr(K_IEN, 2, 0);
        run_for(2, 32'h04, 2);
        mdl[K_CNT][2] = 32'hFFFD;
        reg_chk("R5 down wrap count", K_CNT, 2);
        check("R8 masked irq stays low", 32'(irq[2]), 32'h0);
        bus_rd(K_STAT*3 + 2, v);
        check("R6 overflow flag", v, 32'h10);

        // R3: zero request is write-only
        reg_wr(K_CTRL, 2, 32'h1F);
        reg_chk("R3 zero bit reads 0", K_CTRL, 2);
        reg_chk("R3 zero request clears count", K_CNT, 2);

        // R6: matches A=3, B=100, C=2; 4 ticks -> 1..4
        reg_wr(K_CLK, 0, 0); reg_wr(K_IEN, 0, 0);
        reg_wr(K_MA, 0, 3); reg_wr(K_MB, 0, 100); reg_wr(K_MC, 0, 2);
        run_for(0, 32'h08, 3);
        mdl[K_CNT][0] = 4;
        reg_chk("R6 match run count", K_CNT, 0);
        bus_rd(K_STAT*3 + 0, v);
        check("R6 match flags A and C", v, 32'h0A);

        // R5: prescale S=0 (div 2), 10 edges -> 5 ticks
        reg_wr(K_CLK, 0, 32'h01);
        run_for(0, 32'h00, 9);
        mdl[K_CNT][0] = 5;
        reg_chk("R5 prescale div2", K_CNT, 0);
        // R5: prescale S=1 (div 4), 8 edges -> 2 ticks
        reg_wr(K_CLK, 0, 32'h03);
        run_for(0, 32'h00, 7);
        mdl[K_CNT][0] = 2;
        reg_chk("R5 prescale div4", K_CNT, 0);

        sweep("R1 final map");
        check("R8 all irq low", 32'(irq), 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule